// File: doc/BRIEF.md
# Numeric Coprocessor Exception Status Register

This block keeps the 16-bit status word of a floating-point coprocessor, together with the six exception-mask bits of its control word. The arithmetic units report detected exceptions as a one-cycle event vector. The block turns these events into sticky flags and derives an exception-summary bit from the flags and the masks. A copy of the summary bit appears in the top bit of the word. The block drives an active-low error line back to the host processor.

The block also serves the instructions that touch the word. An environment restore loads the whole word. A clear-exceptions command wipes the flag byte. The initialise command returns everything to its power-on state. An incomplete partial-remainder result clears the condition code. The word is always readable on `sw_o`. The summary bit and its copy are never stored from outside. They are always derived from the flags and masks, so a restore that leaves an unmasked flag set pulls the error line low on the same clock edge that stores the word.

Status word layout: bit 0 invalid, bit 1 denormal, bit 2 zero-divide, bit 3 overflow, bit 4 underflow, bit 5 precision, bit 6 stack fault, bit 7 summary, bits 10..8 condition C2..C0, bits 13..11 stack top, bit 14 condition C3, bit 15 summary copy.

Top module: `fpu_exc_status`

## Requirements
- R1: After reset `sw_o` is 0, `mask_o` is 6'h3F and `err_n_o` is 1.
- R2: A flag in bits 5..0 is set on the edge where `exc_vld_i` is high with the matching bit of `exc_i` (bit 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision). It stays set until a clear, restore or initialise.
- R3: Bit 7 of `sw_o` is 1 exactly when some flag in bits 5..0 is set while its bit in `mask_o` is 0. Bit 15 always equals bit 7.
- R4: On a restore (`ld_i` high), bits 6..0 and 14..8 take the value of `ld_data_i` at the next edge. Bits 7 and 15 ignore the loaded data and are derived from the loaded flags and the masks. Events that arrive in the same cycle are ORed on top of the loaded flags.
- R5: `err_n_o` is a register. It always equals the inverse of bit 7 of `sw_o`, so it falls on the same edge that makes the summary 1, with no further command needed.
- R6: Bit 6 (stack fault) is set when an event has both the invalid bit of `exc_i` and `stk_flt_i` high. It clears with the flags.
- R7: `clr_i` zeroes bits 7..0 and bit 15 at the next edge, which raises `err_n_o`. Events arriving in the same cycle are still recorded.
- R8: The condition code (C3 in bit 14, C2..C0 in bits 10..8) is loaded by `cc_wr_i` from `cc_i` (bit 3 = C3). It is cleared by `prem_inc_i`, which has priority over `cc_wr_i`, and it is also cleared by initialise.
- R9: While the underflow mask (`mask_o[4]`, as held before the edge) is 1, an underflow event sets bit 4 only if `loss_i` is also high. While that mask is 0, an underflow event always sets bit 4.
- R10: `init_i` sets the status word to 0 and all masks to 1 at the next edge, and overrides all other inputs. Restore has priority over clear.
- R11: `mask_wr_i` loads `mask_o` from `mask_i` at the next edge. The flags are unchanged, and the summary is re-derived with the new masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialise command |
| clr_i | input | 1 | Clear-exceptions command |
| ld_i | input | 1 | Environment restore strobe |
| ld_data_i | input | 16 | Status word to restore |
| mask_wr_i | input | 1 | Control-word mask write strobe |
| mask_i | input | 6 | New mask bits |
| exc_vld_i | input | 1 | Exception event valid |
| exc_i | input | 6 | Exception event vector |
| loss_i | input | 1 | Result lost accuracy in denormalisation |
| stk_flt_i | input | 1 | Invalid event caused by stack overflow or underflow |
| cc_wr_i | input | 1 | Condition code write strobe |
| cc_i | input | 4 | Condition code {C3,C2,C1,C0} |
| prem_inc_i | input | 1 | Partial remainder incomplete |
| sw_o | output | 16 | Status word |
| mask_o | output | 6 | Exception masks |
| err_n_o | output | 1 | Error to host, active low |

## Verification
Exception events can reach the block in the same cycle as a clear or a restore, and so can a mask write. In each case the outcome of the collision is defined by priority: a restore or clear first replaces the old flags, and the new events are ORed on top; events are judged against the masks held before the edge. The random stream draws every command independently each cycle, so these overlaps occur often. Directed cases also force each pairing on purpose. Every cycle, the word, the masks and the error line are compared against a bench model that applies the stated priority.

// File: rtl/fpu_exc_status.sv
module fpu_exc_status #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic [15:0]   ld_data_i,
  input  logic          mask_wr_i,
  input  logic [NF-1:0] mask_i,
  input  logic          exc_vld_i,
  input  logic [NF-1:0] exc_i,
  input  logic          loss_i,
  input  logic          stk_flt_i,
  input  logic          cc_wr_i,
  input  logic [3:0]    cc_i,
  input  logic          prem_inc_i,
  output logic [15:0]   sw_o,
  output logic [NF-1:0] mask_o,
  output logic          err_n_o
);
  localparam int UF = 4;
  localparam int IV = 0;

  logic [NF-1:0] flg_q, flg_d, flg_b, ev, msk_q, msk_d;
  logic          sf_q, sf_d, sf_b;
  logic [3:0]    cc_q, cc_d;
  logic [2:0]    top_q, top_d;
  logic          err_n_q, sum;

  always_comb begin
    ev = exc_vld_i ? exc_i : '0;
    ev[UF] = ev[UF] & (~msk_q[UF] | loss_i);
    if (ld_i) begin
      flg_b = ld_data_i[NF-1:0];
      sf_b  = ld_data_i[6];
    end else if (clr_i) begin
      flg_b = '0;
      sf_b  = 1'b0;
    end else begin
      flg_b = flg_q;
      sf_b  = sf_q;
    end
    flg_d = init_i ? '0 : (flg_b | ev);
    sf_d  = init_i ? 1'b0 : (sf_b | (exc_vld_i & stk_flt_i & exc_i[IV]));
    msk_d = init_i ? '1 : (mask_wr_i ? mask_i : msk_q);
    if (init_i)          cc_d = '0;
    else if (ld_i)       cc_d = {ld_data_i[14], ld_data_i[10:8]};
    else if (prem_inc_i) cc_d = '0;
    else if (cc_wr_i)    cc_d = cc_i;
    else                 cc_d = cc_q;
    top_d = init_i ? 3'd0 : (ld_i ? ld_data_i[13:11] : top_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q   <= '0;
      sf_q    <= 1'b0;
      msk_q   <= '1;
      cc_q    <= '0;
      top_q   <= '0;
      err_n_q <= 1'b1;
    end else begin
      flg_q   <= flg_d;
      sf_q    <= sf_d;
      msk_q   <= msk_d;
      cc_q    <= cc_d;
      top_q   <= top_d;
      err_n_q <= ~|(flg_d & ~msk_d);
    end
  end

  assign sum     = |(flg_q & ~msk_q);
  assign sw_o    = {sum, cc_q[3], top_q, cc_q[2:0], sum, sf_q, flg_q};
  assign mask_o  = msk_q;
  assign err_n_o = err_n_q;

  // R5
  err_tracks_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_n_o == ~sw_o[7]);

  // R2
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !ld_i && !clr_i) |=> ((sw_o[5:0] & $past(sw_o[5:0])) == $past(sw_o[5:0])));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ld_i && !init_i && !exc_vld_i) |=> (sw_o[7:0] == 8'h00 && !sw_o[15] && err_n_o));

  // R10
  init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (sw_o == 16'h0000 && mask_o == '1));

  // R9
  uf_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld_i && mask_o[UF] && !loss_i && !sw_o[UF] && !ld_i) |=> !sw_o[UF]);

  // R4
  restore_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !init_i && !exc_vld_i) |=> (sw_o[6:0] == $past(ld_data_i[6:0])));
endmodule

// File: tb/fpu_exc_status_test.sv
module fpu_exc_status_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_i = 0, clr_i = 0, ld_i = 0, mask_wr_i = 0, exc_vld_i = 0;
  logic loss_i = 0, stk_flt_i = 0, cc_wr_i = 0, prem_inc_i = 0;
  logic [15:0] ld_data_i = 0;
  logic [5:0]  mask_i = 0, exc_i = 0;
  logic [3:0]  cc_i = 0;
  logic [15:0] sw_o;
  logic [5:0]  mask_o;
  logic        err_n_o;

  int checks = 0, fails = 0;
  logic [5:0] m_fl = 0, m_mask = 6'h3F;
  logic       m_sf = 0;
  logic [3:0] m_cc = 0;
  logic [2:0] m_top = 0;

  always #(CLK_P/2) clk = ~clk;

  fpu_exc_status uut (.*);

  initial begin
    #(CLK_P*400000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [15:0] exp_sw();
    logic es;
    es = |(m_fl & ~m_mask);
    return {es, m_cc[3], m_top, m_cc[2:0], es, m_sf, m_fl};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model();
    logic [5:0] ev, fb;
    logic sb;
    ev = exc_vld_i ? exc_i : 6'h0;
    ev[4] = ev[4] & (~m_mask[4] | loss_i);
    if (ld_i) begin fb = ld_data_i[5:0]; sb = ld_data_i[6]; end
    else if (clr_i) begin fb = 0; sb = 0; end
    else begin fb = m_fl; sb = m_sf; end
    if (init_i) begin
      m_fl = 0; m_sf = 0; m_mask = 6'h3F; m_cc = 0; m_top = 0;
    end else begin
      m_fl = fb | ev;
      m_sf = sb | (exc_vld_i & stk_flt_i & exc_i[0]);
      if (mask_wr_i) m_mask = mask_i;
      if (ld_i) begin m_cc = {ld_data_i[14], ld_data_i[10:8]}; m_top = ld_data_i[13:11]; end
      else if (prem_inc_i) m_cc = 0;
      else if (cc_wr_i) m_cc = cc_i;
    end
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, {16'h0, sw_o}, {16'h0, exp_sw()});
    chk(tag, {26'h0, mask_o}, {26'h0, m_mask});
    chk("R5", {31'h0, err_n_o}, {31'h0, ~exp_sw()[7]});
    init_i = 0; clr_i = 0; ld_i = 0; mask_wr_i = 0; exc_vld_i = 0;
    loss_i = 0; stk_flt_i = 0; cc_wr_i = 0; prem_inc_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {16'h0, sw_o}, 32'h0);
    chk("R1", {26'h0, mask_o}, 32'h3F);
    chk("R1", {31'h0, err_n_o}, 32'h1);
    rst_n = 1;
    @(negedge clk);

    // R4: restore with summary bits set in data, all masked -> summary 0
    ld_i = 1; ld_data_i = 16'hFFFF; step("R4");
    // R11: unmask zero-divide -> summary and error active
    mask_wr_i = 1; mask_i = 6'h3B; step("R11");
    // R7: clear
    clr_i = 1; step("R7");
    // R7: clear with simultaneous overflow event
    clr_i = 1; exc_vld_i = 1; exc_i = 6'h08; step("R7");
    // R4: restore unmasked flag -> error at once
    mask_wr_i = 1; mask_i = 6'h00; step("R11");
    ld_i = 1; ld_data_i = 16'h0001; step("R4");
    // R10: restore plus init -> init wins
    ld_i = 1; init_i = 1; ld_data_i = 16'h7FFF; step("R10");
    // R9: masked underflow without loss, then with loss
    exc_vld_i = 1; exc_i = 6'h10; step("R9");
    exc_vld_i = 1; exc_i = 6'h10; loss_i = 1; step("R9");
    mask_wr_i = 1; mask_i = 6'h2F; clr_i = 1; step("R9");
    exc_vld_i = 1; exc_i = 6'h10; step("R9");
    // R6: stack fault
    exc_vld_i = 1; exc_i = 6'h01; stk_flt_i = 1; step("R6");
    // R8: cc write, then prem incomplete beats write
    cc_wr_i = 1; cc_i = 4'hF; step("R8");
    cc_wr_i = 1; cc_i = 4'h5; prem_inc_i = 1; step("R8");
    cc_wr_i = 1; cc_i = 4'hA; step("R8");
    init_i = 1; step("R10");
    // R2: sticky accumulation
    exc_vld_i = 1; exc_i = 6'h20; step("R2");
    step("R2");
    mask_wr_i = 1; mask_i = 6'h1F; step("R3");

    for (int i = 0; i < 3000; i++) begin
      init_i    = ($urandom % 50) == 0;
      ld_i      = ($urandom % 12) == 0;
      clr_i     = ($urandom % 8) == 0;
      mask_wr_i = ($urandom % 6) == 0;
      exc_vld_i = ($urandom % 3) == 0;
      cc_wr_i   = ($urandom % 5) == 0;
      prem_inc_i= ($urandom % 9) == 0;
      loss_i    = $urandom;
      stk_flt_i = $urandom;
      ld_data_i = $urandom;
      mask_i    = $urandom;
      exc_i     = $urandom;
      cc_i      = $urandom;
      step("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule